// File: doc/BRIEF.md
# Per-Source Interrupt Trigger Detector

This block is a bank of interrupt request flags with one flag per source. Each source has its own trigger-sense mode: level, falling edge, rising edge or both edges. On every clock the bank samples the (already synchronised) source lines. It compares each line against a registered copy of its previous value and decides whether that line raises a request. The result is a pending-flag vector for the arbiter, together with two per-source strobes. One strobe marks a newly detected event. The other marks a level request that has been withdrawn, so the arbiter can retract a request it has already presented.

Software reaches the block through a small register port with two banks, chosen by `reg_sel_i`. Bank 0 holds the pending flags, one register per source. Bank 1 holds the sense-control registers, one per external pin. The pins cover a parameterised contiguous group of sources, which by default is sources 64 to 95. Every other source keeps the sense mode it was given at build time. The arbiter clears edge-mode flags through the acknowledge port.

Top module: `trig_detect_bank`

## Requirements
- R1: The sense code is 2 bits: 0 = level, 1 = falling edge, 2 = rising edge, 3 = both edges. A write to pin register p (bank 1, index p < PIN_COUNT) takes the mode from write-data bits [3:2]. A read returns the mode in bits [3:2] and zero in all other bits.
- R2: In level mode, the pending flag on the cycle after a sampling edge equals the input sampled at that edge. The event strobe pulses when the flag goes from 0 to 1.
- R3: When a pending level-mode flag drops because its input went low, the withdraw strobe for that source pulses high for one cycle, in the same cycle that the flag reads 0.
- R4: In an edge mode, a qualifying transition between the previous sample and the current sample sets the pending flag one cycle later, with a one-cycle event strobe. A non-qualifying transition sets nothing.
- R5: An edge-mode pending flag stays set until either an acknowledge names that source or software writes to its flag register with bit 0 = 0. Acknowledges and software clears have no effect on level-mode sources.
- R6: A flag-register write with bit 0 = 1 never changes a flag. A write with bit 0 = 0 to a level-mode source is ignored.
- R7: After reset all pending flags are 0. Every source is in rising-edge mode, except those whose bit is set in LEVEL_MASK, which come up in level mode.
- R8: A flag index of NUM_SRC or above, or a pin index of PIN_COUNT or above, changes no state and reads as 0. An acknowledge with an out-of-range index changes no state.
- R9: Reading a flag register (bank 0) returns the pending flag in bit 0 and zero in bits [7:1].
- R10: If a qualifying edge and a clear (acknowledge or software) reach the same source in the same cycle, the edge wins and the flag stays set.
- R11: A pin register write changes the sense mode of source PIN_BASE+p only. The sense mode of sources outside the pin group stays fixed at its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Synchronised source request lines |
| ack_valid_i | input | 1 | Acknowledge from the arbiter |
| ack_idx_i | input | IDX_W | Source index being acknowledged |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Bank select: 0 = pending flags, 1 = pin sense control |
| reg_idx_i | input | IDX_W | Register index within the bank |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| pend_o | output | NUM_SRC | Pending flag per source |
| event_o | output | NUM_SRC | One-cycle strobe per newly detected event |
| withdraw_o | output | NUM_SRC | One-cycle strobe when a level request drops |

## Verification
Two things can land on the same source in one cycle: a fresh qualifying edge and a clear, whether that clear comes from the arbiter or from software. The bench provokes this directly by raising a rising-edge source in the same cycle that it acknowledges that source. It then expects the flag to stay set. The bench repeats the same kind of clash under random stimulus, using a cycle-accurate model that gives the edge precedence. Level sources are also hit with acknowledges and clearing writes while high, and the bench expects the flag to keep following the input.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL = 2'd0,
    SENSE_FALL  = 2'd1,
    SENSE_RISE  = 2'd2,
    SENSE_BOTH  = 2'd3
  } sense_e;

  localparam int unsigned SENSE_W   = 2;
  localparam int unsigned SENSE_LSB = 2;
  localparam int unsigned DATA_W    = 8;

  function automatic logic edge_hit(sense_e mode, logic prev, logic cur);
    unique case (mode)
      SENSE_FALL: edge_hit = prev & ~cur;
      SENSE_RISE: edge_hit = ~prev & cur;
      SENSE_BOTH: edge_hit = prev ^ cur;
      default:    edge_hit = 1'b0;
    endcase
  endfunction

  function automatic sense_e reset_mode(logic is_level);
    reset_mode = is_level ? SENSE_LEVEL : SENSE_RISE;
  endfunction

endpackage

// File: rtl/trig_cell.sv
module trig_cell
  import trig_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   src_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   pend_o,
  output logic   event_o,
  output logic   withdraw_o
);

  logic prev_q, pend_q, evt_q, wdr_q;
  logic pend_d, evt_d, wdr_d, hit;

  always_comb begin
    hit = edge_hit(sense_i, prev_q, src_i);
    if (sense_i == SENSE_LEVEL) begin
      pend_d = src_i;
      evt_d  = src_i & ~pend_q;
      wdr_d  = pend_q & ~src_i;
    end else begin
      evt_d  = hit;
      wdr_d  = 1'b0;
      // a new edge takes precedence over a clear in the same cycle
      if (hit)        pend_d = 1'b1;
      else if (clr_i) pend_d = 1'b0;
      else            pend_d = pend_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
      wdr_q  <= 1'b0;
    end else begin
      prev_q <= src_i;
      pend_q <= pend_d;
      evt_q  <= evt_d;
      wdr_q  <= wdr_d;
    end
  end

  assign pend_o     = pend_q;
  assign event_o    = evt_q;
  assign withdraw_o = wdr_q;

endmodule

// File: rtl/trig_sense_bank.sv
module trig_sense_bank
  import trig_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 128,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned PIN_BASE   = 64,
  parameter int unsigned PIN_COUNT  = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [IDX_W-1:0]               wr_pin_i,
  input  logic [SENSE_W-1:0]             wr_mode_i,
  output logic [NUM_SRC-1:0][SENSE_W-1:0] sense_o
);

  localparam int unsigned PIN_END = PIN_BASE + PIN_COUNT;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [SENSE_W-1:0] RST_MODE = reset_mode(LEVEL_MASK[i]);
    if (i >= PIN_BASE && i < PIN_END) begin : g_pin
      logic [SENSE_W-1:0] mode_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mode_q <= RST_MODE;
        end else if (wr_en_i && wr_pin_i == IDX_W'(i - PIN_BASE)) begin
          mode_q <= wr_mode_i;
        end
      end
      assign sense_o[i] = mode_q;
    end else begin : g_fixed
      assign sense_o[i] = RST_MODE;
    end
  end

endmodule

// File: rtl/trig_reg_read.sv
module trig_reg_read
  import trig_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 128,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned PIN_BASE  = 64,
  parameter int unsigned PIN_COUNT = 32
) (
  input  logic                            sel_i,
  input  logic [IDX_W-1:0]                idx_i,
  input  logic [NUM_SRC-1:0]              pend_i,
  input  logic [NUM_SRC-1:0][SENSE_W-1:0] sense_i,
  output logic [DATA_W-1:0]               rdata_o
);

  always_comb begin
    rdata_o = '0;
    if (!sel_i) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (idx_i == IDX_W'(i)) rdata_o = {{(DATA_W-1){1'b0}}, pend_i[i]};
      end
    end else begin
      for (int p = 0; p < PIN_COUNT; p++) begin
        if (idx_i == IDX_W'(p)) begin
          rdata_o = '0;
          rdata_o[SENSE_LSB +: SENSE_W] = sense_i[PIN_BASE + p];
        end
      end
    end
  end

endmodule

// File: rtl/trig_detect_bank.sv
module trig_detect_bank
  import trig_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 128,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned PIN_BASE  = 64,
  parameter int unsigned PIN_COUNT = 32,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK =
    128'h0000_0000_0000_0040_0000_0000_0002_0008
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               ack_valid_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  input  logic               reg_we_i,
  input  logic               reg_sel_i,
  input  logic [IDX_W-1:0]   reg_idx_i,
  input  logic [7:0]         reg_wdata_i,
  output logic [7:0]         reg_rdata_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic [NUM_SRC-1:0] event_o,
  output logic [NUM_SRC-1:0] withdraw_o
);

  logic [NUM_SRC-1:0][SENSE_W-1:0] sense_w;
  logic [NUM_SRC-1:0]              clr_w;
  logic                            sw_clr_en, pin_wr_en;

  assign sw_clr_en = reg_we_i & ~reg_sel_i & ~reg_wdata_i[0];
  assign pin_wr_en = reg_we_i & reg_sel_i;

  trig_sense_bank #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PIN_BASE(PIN_BASE),
    .PIN_COUNT(PIN_COUNT), .LEVEL_MASK(LEVEL_MASK)
  ) i_sense (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (pin_wr_en),
    .wr_pin_i (reg_idx_i),
    .wr_mode_i(reg_wdata_i[SENSE_LSB +: SENSE_W]),
    .sense_o  (sense_w)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    assign clr_w[i] = (ack_valid_i && ack_idx_i == IDX_W'(i)) ||
                      (sw_clr_en && reg_idx_i == IDX_W'(i));
    trig_cell i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i[i]),
      .sense_i   (sense_e'(sense_w[i])),
      .clr_i     (clr_w[i]),
      .pend_o    (pend_o[i]),
      .event_o   (event_o[i]),
      .withdraw_o(withdraw_o[i])
    );
  end

  trig_reg_read #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .PIN_BASE(PIN_BASE), .PIN_COUNT(PIN_COUNT)
  ) i_read (
    .sel_i  (reg_sel_i),
    .idx_i  (reg_idx_i),
    .pend_i (pend_o),
    .sense_i(sense_w),
    .rdata_o(reg_rdata_o)
  );

endmodule

// File: rtl/trig_detect_bank_chk.sv
module trig_detect_bank_chk #(
  parameter int unsigned NUM_SRC = 128,
  parameter int unsigned IDX_W   = 8
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NUM_SRC-1:0]        src_i,
  input logic                      ack_valid_i,
  input logic [IDX_W-1:0]          ack_idx_i,
  input logic                      reg_we_i,
  input logic                      reg_sel_i,
  input logic [IDX_W-1:0]          reg_idx_i,
  input logic [7:0]                reg_wdata_i,
  input logic [NUM_SRC-1:0]        pend_o,
  input logic [NUM_SRC-1:0]        event_o,
  input logic [NUM_SRC-1:0]        withdraw_o,
  input logic [NUM_SRC-1:0][1:0]   sense_w
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
    logic clr;
    assign clr = (ack_valid_i && ack_idx_i == IDX_W'(i)) ||
                 (reg_we_i && !reg_sel_i && reg_idx_i == IDX_W'(i) && !reg_wdata_i[0]);

    assert_level_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_w[i] == 2'd0) |=> (pend_o[i] == $past(src_i[i])));

    assert_withdraw_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      withdraw_o[i] |-> (!pend_o[i] && $past(pend_o[i]) && !$past(src_i[i])));

    assert_event_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      event_o[i] |-> pend_o[i]);

    assert_rise_needs_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_w[i] == 2'd2 && !src_i[i]) |=> !event_o[i]);

    assert_edge_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_w[i] != 2'd0 && pend_o[i] && !clr) |=> pend_o[i]);

    assert_new_edge_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sense_w[i] == 2'd2 && src_i[i] && !$past(src_i[i])) |=> pend_o[i]);
  end

endmodule

bind trig_detect_bank trig_detect_bank_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_i      (src_i),
  .ack_valid_i(ack_valid_i),
  .ack_idx_i  (ack_idx_i),
  .reg_we_i   (reg_we_i),
  .reg_sel_i  (reg_sel_i),
  .reg_idx_i  (reg_idx_i),
  .reg_wdata_i(reg_wdata_i),
  .pend_o     (pend_o),
  .event_o    (event_o),
  .withdraw_o (withdraw_o),
  .sense_w    (sense_w)
);

// File: tb/test_trig_detect_bank.sv
module test_trig_detect_bank;
  localparam int N = 128;
  localparam int PB = 64;
  localparam int PC = 32;
  localparam logic [N-1:0] LMASK = 128'h0000_0000_0000_0040_0000_0000_0002_0008;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic ack_v = 1'b0, we = 1'b0, sel = 1'b0;
  logic [7:0] ack_idx = '0, idx = '0, wd = '0;
  logic [7:0] rdata;
  logic [N-1:0] pend, evt, wdr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_pend, m_prev, x_pend, x_evt, x_wdr;
  logic [1:0]   m_sense [N];

  always #2.5 clk = ~clk;

  trig_detect_bank i_trig_detect_bank (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .ack_valid_i(ack_v), .ack_idx_i(ack_idx),
    .reg_we_i(we), .reg_sel_i(sel), .reg_idx_i(idx), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .pend_o(pend), .event_o(evt), .withdraw_o(wdr)
  );

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // bench model of one clock edge
  task automatic cycle();
    for (int i = 0; i < N; i++) begin
      logic clr, hit;
      clr = (ack_v && ack_idx == 8'(i)) || (we && !sel && idx == 8'(i) && !wd[0]);
      case (m_sense[i])
        2'd1: hit = m_prev[i] & ~src[i];
        2'd2: hit = ~m_prev[i] & src[i];
        2'd3: hit = m_prev[i] ^ src[i];
        default: hit = 1'b0;
      endcase
      if (m_sense[i] == 2'd0) begin
        x_pend[i] = src[i]; x_evt[i] = src[i] & ~m_pend[i]; x_wdr[i] = m_pend[i] & ~src[i];
      end else begin
        x_evt[i] = hit; x_wdr[i] = 1'b0;
        x_pend[i] = hit ? 1'b1 : (clr ? 1'b0 : m_pend[i]);
      end
    end
    @(posedge clk);
    @(negedge clk);
    if (we && sel && idx < 8'(PC)) m_sense[PB + int'(idx)] = wd[3:2];
    m_pend = x_pend;
    m_prev = src;
    check("R2 R3 R4 R5 pend", pend, x_pend);
    check("R2 R4 event", evt, x_evt);
    check("R3 withdraw", wdr, x_wdr);
    we = 1'b0; ack_v = 1'b0;
  endtask

  function automatic logic [7:0] exp_read(logic s, logic [7:0] ix);
    if (!s) return (ix < 8'(N)) ? {7'b0, m_pend[ix[6:0]]} : 8'h00;
    return (ix < 8'(PC)) ? {4'b0, m_sense[PB + int'(ix)], 2'b00} : 8'h00;
  endfunction

  task automatic rd(string tag, logic s, logic [7:0] ix, logic [7:0] exp);
    sel = s; idx = ix; #0.5;
    check(tag, N'(rdata), N'(exp));
    check({tag, " model"}, N'(rdata), N'(exp_read(s, ix)));
  endtask

  task automatic wr(logic s, logic [7:0] ix, logic [7:0] d);
    we = 1'b1; sel = s; idx = ix; wd = d;
    cycle();
  endtask

  task automatic do_ack(logic [7:0] ix);
    ack_v = 1'b1; ack_idx = ix;
    cycle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] snap;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < N; i++) m_sense[i] = LMASK[i] ? 2'd0 : 2'd2;
    m_pend = '0; m_prev = '0;
    repeat (3) @(negedge clk);
    check("R7 pend after reset", pend, '0);
    rst_n = 1'b1;
    @(negedge clk);
    rd("R7 pin 6 level", 1'b1, 8'd6, 8'h00);
    rd("R7 pin 0 rise", 1'b1, 8'd0, 8'h08);

    src[3] = 1'b1; cycle();
    check("R2 level set", N'(pend[3]), N'(1)); check("R2 level event", N'(evt[3]), N'(1));
    wr(1'b0, 8'd3, 8'h00);
    check("R6 level sw clear ignored", N'(pend[3]), N'(1));
    src[3] = 1'b0; cycle();
    check("R3 level drop", N'(pend[3]), N'(0)); check("R3 withdraw", N'(wdr[3]), N'(1));

    src[10] = 1'b1; cycle();
    check("R4 rise set", N'(pend[10]), N'(1)); check("R4 rise event", N'(evt[10]), N'(1));
    cycle();
    check("R4 event one cycle", N'(evt[10]), N'(0));
    rd("R9 flag read", 1'b0, 8'd10, 8'h01);
    wr(1'b0, 8'd11, 8'hFF);
    check("R6 write one ignored", N'(pend[11]), N'(0));
    do_ack(8'd10);
    check("R5 ack clears", N'(pend[10]), N'(0));
    src[10] = 1'b0; cycle();
    src[10] = 1'b1; ack_v = 1'b1; ack_idx = 8'd10; cycle();
    check("R10 edge beats ack", N'(pend[10]), N'(1));
    wr(1'b0, 8'd10, 8'hFE);
    check("R5 sw clear", N'(pend[10]), N'(0));

    wr(1'b1, 8'd1, 8'hF7);
    rd("R1 pin fall readback", 1'b1, 8'd1, 8'h04);
    src[65] = 1'b1; cycle();
    check("R4 fall ignores rise", N'(pend[65]), N'(0));
    src[65] = 1'b0; cycle();
    check("R4 fall sets", N'(pend[65]), N'(1));
    wr(1'b1, 8'd2, 8'h0C);
    src[66] = 1'b1; cycle();
    check("R4 both rise", N'(pend[66]), N'(1));
    do_ack(8'd66);
    src[66] = 1'b0; cycle();
    check("R4 both fall", N'(pend[66]), N'(1));

    wr(1'b1, 8'd0, 8'h00);
    src[64] = 1'b1; cycle();
    check("R11 pin to level", N'(pend[64]), N'(1));
    src[64] = 1'b0; cycle();
    check("R11 pin level drop", N'(wdr[64]), N'(1));

    snap = pend;
    wr(1'b0, 8'd200, 8'h00);
    check("R8 flag idx out of range", pend, snap);
    do_ack(8'd200);
    check("R8 ack out of range", pend, snap);
    wr(1'b1, 8'd40, 8'h0C);
    rd("R8 pin read out of range", 1'b1, 8'd40, 8'h00);
    rd("R8 flag read out of range", 1'b0, 8'd200, 8'h00);

    src[3] = 1'b1; cycle();
    do_ack(8'd3);
    check("R5 ack ignored on level", N'(pend[3]), N'(1));

    for (int c = 0; c < 3000; c++) begin
      for (int k = 0; k < 4; k++) src[$urandom % N] ^= 1'b1;
      if ($urandom % 4 == 0) begin ack_v = 1'b1; ack_idx = 8'($urandom % 160); end
      if ($urandom % 6 == 0) begin
        we = 1'b1; sel = 1'($urandom % 2);
        idx = sel ? 8'($urandom % 40) : 8'($urandom % 160);
        wd = 8'($urandom);
      end
      cycle();
      if (c % 50 == 0) begin
        int ri = $urandom % 160;
        int s = $urandom % 2;
        rd("R1 R9 random read", 1'(s), 8'(ri), exp_read(1'(s), 8'(ri)));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule